// File: doc/BRIEF.md
# Frame Base Address Latch with Interrupt

This block holds the frame buffer start address that a display fetch engine reads from. A host writes a new base address into a pending register at any moment. The new value takes effect in the active register only at the next frame-start pulse, so a frame that has already started keeps fetching from a single buffer. Page flips therefore never tear.

When a written address becomes active, the block raises a base-taken status bit. That bit joins a small vector of interrupt status bits. The other bits are set by side event inputs from the surrounding display logic. Software sees the following:
- the raw status;
- a per-bit enable mask;
- the masked status;
- a write-one-to-clear path.

A single level interrupt line is high whenever any enabled status bit is set.

The register port is a plain write strobe with a two-bit select, plus a combinational read select. The select codes are:

| Code | Read returns | Write does |
|------|--------------|------------|
| 0 | pending base address | writes the pending base address |
| 1 | enable mask | writes the enable mask |
| 2 | raw status | clears status bits, one per written 1 |
| 3 | masked status | nothing |

Top module: `fbl_frame_base_latch`

## Requirements
- R1: After reset, the active base, the pending base, the enable mask and the raw status are all zero, and the interrupt line is low.
- R2: A write with select 0 stores the data in the pending base with bits [1:0] forced to zero. The stored value reads back with read select 0 from the next cycle. The active base does not change on that write.
- R3: On a frame-start pulse with a write pending since the last transfer, the active base takes the pending value at that clock edge. Raw status bit UPD_BIT (0 by default) sets at the same edge.
- R4: A frame-start pulse with no write since the last transfer leaves the active base unchanged and sets no status bit.
- R5: A base write in the same cycle as a frame-start pulse does not transfer the new value at that boundary. It is transferred at the next frame-start pulse.
- R6: A 1 on side_evt_i[i] sets raw status bit i at the next clock edge. Raw status reads with read select 2.
- R7: The masked status equals raw status AND enable mask. It is visible on masked_o and reads with read select 3. The enable mask is written with select 1.
- R8: A write with select 2 clears each raw status bit whose data bit is 1 and leaves the other bits unchanged. A write with select 3 has no effect.
- R9: When a set event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: irq_o is the OR of all masked status bits. It is low while the enable mask is zero, whatever the raw status.
- R11: Bits [1:0] of the active base are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle pulse at each frame boundary |
| side_evt_i | input | NSRC | Per-bit status set events from other display logic |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select (0 base, 1 enable, 2 clear, 3 none) |
| wr_data_i | input | ADDR_W | Write data |
| rd_sel_i | input | 2 | Read select (0 base, 1 enable, 2 raw, 3 masked) |
| rd_data_o | output | ADDR_W | Read data, combinational from rd_sel_i |
| active_base_o | output | ADDR_W | Base address in use by the fetch engine |
| masked_o | output | NSRC | Masked interrupt status |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are collisions in a single cycle. One is a base write landing exactly on a frame-start pulse. The other is a clear write hitting the base-taken bit in the very cycle that bit is being set. Random stimulus reaches these only rarely, so directed steps create both on purpose and then check the following frame boundary. A long random phase then mixes writes, clears, enable changes and frame pulses against a cycle model kept in the bench.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_MASKED = 2'd3
  } fbl_sel_e;
endpackage

// File: rtl/fbl_base_dbuf.sv
module fbl_base_dbuf #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic              frame_start_i,
  output logic [ADDR_W-1:0] pend_o,
  output logic [ADDR_W-1:0] active_o,
  output logic              arm_o,
  output logic              upd_evt_o
);
  localparam int ALIGN_BITS = 2;

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] pend_q, active_q;
  logic              arm_q;

  assign upd_evt_o = frame_start_i & arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= '0;
      arm_q    <= 1'b0;
    end else begin
      if (wr_i) pend_q <= word_align(data_i);
      if (upd_evt_o) active_q <= pend_q;
      if (wr_i) arm_q <= 1'b1;
      else if (frame_start_i) arm_q <= 1'b0;
    end
  end

  assign pend_o   = pend_q;
  assign active_o = active_q;
  assign arm_o    = arm_q;
endmodule

// File: rtl/fbl_irq_ctrl.sv
module fbl_irq_ctrl #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_data_i,
  output logic [NSRC-1:0] raw_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] masked_o,
  output logic            irq_o
);
  function automatic logic [NSRC-1:0] next_status(input logic [NSRC-1:0] cur,
                                                  input logic [NSRC-1:0] clr,
                                                  input logic [NSRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [NSRC-1:0] raw_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= next_status(raw_q, clr_i, set_i);
      if (en_wr_i) en_q <= en_data_i;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/fbl_frame_base_latch.sv
module fbl_frame_base_latch #(
  parameter int ADDR_W  = 32,
  parameter int NSRC    = 4,
  parameter int UPD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [NSRC-1:0]   side_evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] active_base_o,
  output logic [NSRC-1:0]   masked_o,
  output logic              irq_o
);
  import fbl_pkg::*;

  localparam int PAD_W = ADDR_W - NSRC;

  logic              base_wr, en_wr;
  logic [NSRC-1:0]   clr_vec, set_vec, raw_vec, en_vec;
  logic [ADDR_W-1:0] pend_base;
  logic              arm_w, upd_evt;

  assign base_wr = wr_en_i && (wr_sel_i == SEL_BASE);
  assign en_wr   = wr_en_i && (wr_sel_i == SEL_ENABLE);
  assign clr_vec = (wr_en_i && (wr_sel_i == SEL_STATUS)) ? wr_data_i[NSRC-1:0] : '0;

  always_comb begin
    set_vec = side_evt_i;
    set_vec[UPD_BIT] = side_evt_i[UPD_BIT] | upd_evt;
  end

  fbl_base_dbuf #(.ADDR_W(ADDR_W)) u_dbuf (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (base_wr),
    .data_i        (wr_data_i),
    .frame_start_i (frame_start_i),
    .pend_o        (pend_base),
    .active_o      (active_base_o),
    .arm_o         (arm_w),
    .upd_evt_o     (upd_evt)
  );

  fbl_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .en_wr_i   (en_wr),
    .en_data_i (wr_data_i[NSRC-1:0]),
    .raw_o     (raw_vec),
    .en_o      (en_vec),
    .masked_o  (masked_o),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (fbl_sel_e'(rd_sel_i))
      SEL_BASE:   rd_data_o = pend_base;
      SEL_ENABLE: rd_data_o = {{PAD_W{1'b0}}, en_vec};
      SEL_STATUS: rd_data_o = {{PAD_W{1'b0}}, raw_vec};
      default:    rd_data_o = {{PAD_W{1'b0}}, masked_o};
    endcase
  end
endmodule

// File: rtl/fbl_frame_base_latch_chk.sv
module fbl_frame_base_latch_chk #(
  parameter int ADDR_W  = 32,
  parameter int NSRC    = 4,
  parameter int UPD_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start_i,
  input logic              arm_w,
  input logic              upd_evt,
  input logic [ADDR_W-1:0] pend_base,
  input logic [ADDR_W-1:0] active_base_o,
  input logic [NSRC-1:0]   raw_vec,
  input logic [NSRC-1:0]   en_vec,
  input logic [NSRC-1:0]   clr_vec,
  input logic [NSRC-1:0]   side_evt_i,
  input logic              irq_o
);
  // R3
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && arm_w) |=> (active_base_o == $past(pend_base)));

  // R4
  idle_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !arm_w) |=> $stable(active_base_o));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> raw_vec[UPD_BIT]);

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[UPD_BIT] && !upd_evt && !side_evt_i[UPD_BIT]) |=> !raw_vec[UPD_BIT]);

  // R10
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !irq_o);

  // R11
  always_comb begin
    if (rst_n) begin
      align_chk: assert (active_base_o[1:0] == 2'b00);
    end
  end
endmodule

bind fbl_frame_base_latch fbl_frame_base_latch_chk #(
  .ADDR_W(ADDR_W), .NSRC(NSRC), .UPD_BIT(UPD_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_i (frame_start_i),
  .arm_w         (arm_w),
  .upd_evt       (upd_evt),
  .pend_base     (pend_base),
  .active_base_o (active_base_o),
  .raw_vec       (raw_vec),
  .en_vec        (en_vec),
  .clr_vec       (clr_vec),
  .side_evt_i    (side_evt_i),
  .irq_o         (irq_o)
);

// File: tb/tb_fbl_frame_base_latch.sv
module tb_fbl_frame_base_latch;
  localparam int AW = 32;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs = 1'b0;
  logic [NS-1:0] evt = '0;
  logic          we = 1'b0;
  logic [1:0]    wsel = '0;
  logic [AW-1:0] wdat = '0;
  logic [1:0]    rsel = '0;
  logic [AW-1:0] rd_data;
  logic [AW-1:0] active;
  logic [NS-1:0] masked;
  logic          irq;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [AW-1:0] m_pend = '0, m_active = '0;
  logic          m_arm = 1'b0;
  logic [NS-1:0] m_raw = '0, m_en = '0;

  always #10 clk = ~clk;

  fbl_frame_base_latch dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .side_evt_i(evt),
    .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wdat), .rd_sel_i(rsel),
    .rd_data_o(rd_data), .active_base_o(active), .masked_o(masked), .irq_o(irq)
  );

  function automatic logic [AW-1:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return m_pend;
      2'd1:    return AW'(m_en);
      2'd2:    return AW'(m_raw);
      default: return AW'(m_raw & m_en);
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check({req, " active"}, active, m_active);
    check({req, " rd"}, rd_data, exp_rd(rsel));
    check({req, " masked R7"}, AW'(masked), AW'(m_raw & m_en));
    check({req, " irq R10"}, AW'(irq), AW'(|(m_raw & m_en)));
    check({req, " align R11"}, AW'(active[1:0]), '0);
  endtask

  task automatic step(input string req, input logic w, input logic [1:0] s,
                      input logic [AW-1:0] d, input logic f, input logic [NS-1:0] e,
                      input logic [1:0] r);
    logic [NS-1:0] clr, set;
    @(negedge clk);
    we = w; wsel = s; wdat = d; fs = f; evt = e; rsel = r;
    #1;
    compare_all(req);
    @(posedge clk);
    clr = (w && s == 2'd2) ? d[NS-1:0] : '0;
    set = e | ((f && m_arm) ? NS'(1) : '0);
    if (f && m_arm) m_active = m_pend;
    if (w && s == 2'd0) begin
      m_pend = {d[AW-1:2], 2'b00};
      m_arm = 1'b1;
    end else if (f) m_arm = 1'b0;
    if (w && s == 2'd1) m_en = d[NS-1:0];
    m_raw = (m_raw & ~clr) | set;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #45;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rsel = 2'(i);
      #1;
      check("R1 reset rd", rd_data, '0);
    end
    check("R1 reset active", active, '0);
    check("R1 reset irq", AW'(irq), '0);
    rst_n = 1'b1;

    // R2 base write with unaligned low bits, active unchanged
    step("R2", 1, 2'd0, 32'h1234_5677, 0, '0, 2'd0);
    step("R2", 0, 2'd0, '0, 0, '0, 2'd0);
    check("R2 pend aligned", rd_data, 32'h1234_5674);
    step("R2", 0, 2'd0, '0, 0, '0, 2'd2);
    // R3 transfer at frame start, status bit set
    step("R3", 1, 2'd1, 32'h1, 1, '0, 2'd2);
    step("R3", 0, 2'd0, '0, 0, '0, 2'd2);
    check("R3 active", active, 32'h1234_5674);
    check("R3 raw", rd_data, 32'h1);
    // R8 clear, and R4 idle frame
    step("R8", 1, 2'd2, 32'h1, 0, '0, 2'd2);
    step("R4", 0, 2'd0, '0, 1, '0, 2'd2);
    step("R4", 0, 2'd0, '0, 0, '0, 2'd2);
    check("R4 no status", rd_data, '0);
    // R5 write coincident with frame start
    step("R5", 1, 2'd0, 32'hAAAA_0000, 0, '0, 2'd0);
    step("R5", 1, 2'd0, 32'hBBBB_0000, 1, '0, 2'd0);
    step("R5", 0, 2'd0, '0, 0, '0, 2'd0);
    check("R5 old taken", active, 32'hAAAA_0000);
    step("R5", 0, 2'd0, '0, 1, '0, 2'd0);
    step("R5", 0, 2'd0, '0, 0, '0, 2'd0);
    check("R5 new taken", active, 32'hBBBB_0000);
    // R9 set wins over clear: arm then clear in frame cycle
    step("R9", 1, 2'd2, 32'hF, 0, '0, 2'd2);
    step("R9", 1, 2'd0, 32'h0000_1000, 0, '0, 2'd2);
    step("R9", 1, 2'd2, 32'h1, 1, '0, 2'd2);
    step("R9", 0, 2'd0, '0, 0, '0, 2'd2);
    check("R9 set kept", AW'(rd_data[0]), 32'h1);
    // R6 side events, R8 selective clear, R8 select 3 write ignored
    step("R6", 0, 2'd0, '0, 0, 4'b1010, 2'd2);
    step("R6", 1, 2'd3, 32'hF, 0, '0, 2'd2);
    step("R8", 0, 2'd0, '0, 0, '0, 2'd2);
    check("R6 raw", rd_data, 32'hB);
    step("R8", 1, 2'd2, 32'h2, 0, '0, 2'd2);
    step("R8", 0, 2'd0, '0, 0, '0, 2'd2);
    check("R8 selective", rd_data, 32'h9);
    // R10 mask all, then enable one
    step("R10", 1, 2'd1, 32'h0, 0, '0, 2'd3);
    step("R10", 0, 2'd0, '0, 0, '0, 2'd3);
    check("R10 masked off", AW'(irq), '0);
    step("R7", 1, 2'd1, 32'h8, 0, '0, 2'd3);
    step("R7", 0, 2'd0, '0, 0, '0, 2'd3);
    check("R7 masked rd", rd_data, 32'h8);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      logic w;
      w = ($urandom % 10) < 3;
      step("RND R2 R3 R6 R8", w, 2'($urandom), $urandom, ($urandom % 8) == 0,
           (($urandom % 6) == 0) ? NS'($urandom) : '0, 2'($urandom));
    end
    step("END", 0, 2'd0, '0, 0, '0, 2'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule